// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Bank

This block is the digital front of a four-channel voltage-output converter. Each channel keeps two registers. The staging register is filled through a simple byte-wide register bus. The live register holds the code that drives the converter. A value written to a channel stays in its staging register and has no effect on the output until a load command copies it into the live register. This lets software prepare new codes on several channels and then switch all of them together.

There are two sources for the load command, and a mode bit chooses between them. In pin mode, an active-low load input is brought through a two-flop synchronizer, and its high-to-low transition loads every channel at once. In software mode, the pin is ignored. Instead, a write to a load register sets a one-cycle strobe for each channel whose bit is one, and only those channels load. Reading a channel's register address returns the live code, not the staged one. Firmware can therefore confirm which value the output actually carries.

Top module: `quad_dac_bank`

## Requirements
- R1: After reset, every channel code is 0, the load source is the pin, and a read of any mapped address returns 0x00.
- R2: A write to a channel register changes only the staging register. The channel code output stays unchanged until a load command reaches that channel.
- R3: A read of a channel address returns the live code, even before a load. The layout is as follows. For a channel at offset c, address 0x10+2c is the low register, which holds code[1:0] in bits 7:6 and zeros elsewhere. Address 0x10+2c+1 is the high register, which holds code[7:2] in bits 5:0 and zeros in bits 7:6.
- R4: In pin mode, take the first rising clock edge at which load_n is sampled low as edge k. All four codes take their staged values at edge k+2 and are unchanged before it.
- R5: Holding load_n low produces exactly one load. A write made while the pin stays low is not loaded until the pin goes high and falls again.
- R6: Bit 3 of the control register at 0x1A selects the load source, where 1 means software. In software mode, transitions on load_n change no code. The control register reads back as that bit in position 3 with zeros elsewhere.
- R7: In software mode, suppose a write of mask m goes to the load register at 0x1C at edge k. Then at edge k+1, exactly the channels i with m[i]=1 take their staged values, and the others keep their codes. The strobe clears by itself, and the load register reads as 0x00.
- R8: In pin mode, writes to the load register change no code.
- R9: A write to a high register uses only data bits 5:0, and a write to a low register uses only data bits 7:6. The other data bits have no effect on the staged code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Register address for both write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| load_n | input | 1 | Asynchronous active-low load pin |
| dac_code | output | NCH*CODE_W | Live codes, channel i in bits [i*CODE_W +: CODE_W] |

## Verification
The bench goes after several corner cases.

- It checks the exact cycle of a pin load. A design with a missing or extra synchronizer stage would update one edge early or late.
- It holds the pin low while writing new data. A level-sensitive load would copy the new data before the pin returns high.
- It reads channel addresses between a write and its load. A design that echoed the staging register would return the new value too early.
- It issues partial-mask software loads and loads from the mode that is not selected. Leaking strobes would update channels that were not chosen, and a strobe that failed to clear would keep copying later writes.
- It writes data bits outside each field. A design that did not mask them would put them into the staged code.

// File: rtl/qdb_pkg.sv
package qdb_pkg;

   typedef enum logic {
      LDSRC_PIN = 1'b0,
      LDSRC_SW  = 1'b1
   } ld_src_e;

   // Width of the low-register field for a given code width.
   function automatic int low_field_w(input int code_w);
      return (code_w >= 10) ? (code_w - 8) : 2;
   endfunction

   // Reports whether the code width is one of the supported variants.
   function automatic bit code_w_ok(input int code_w);
      return (code_w == 8) || (code_w == 10) || (code_w == 12);
   endfunction

endpackage

// File: rtl/qdb_pin_edge.sv
module qdb_pin_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("qdb_pin_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain  <= '1;
         last_q <= 1'b1;
      end else begin
         chain  <= {chain[STAGES-2:0], pin_n};
         last_q <= chain[STAGES-1];
      end
   end

   assign fall = last_q & ~chain[STAGES-1];

   // R5
   single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

   // R4
   fall_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |-> $past(chain[STAGES-1]));

endmodule

// File: rtl/qdb_channel.sv
module qdb_channel #(
   parameter int CODE_W = 8,
   parameter int LOW_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              low_we,
   input  logic              high_we,
   input  logic [7:0]        wdata,
   input  logic              load,
   output logic [CODE_W-1:0] code,
   output logic [7:0]        rd_low,
   output logic [7:0]        rd_high
);
   localparam int HIGH_W = CODE_W - LOW_W;

   logic [CODE_W-1:0] staged;
   logic [CODE_W-1:0] live;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         staged <= '0;
         live   <= '0;
      end else begin
         if (low_we)  staged[LOW_W-1:0]      <= wdata[7 -: LOW_W];
         if (high_we) staged[CODE_W-1:LOW_W] <= wdata[HIGH_W-1:0];
         if (load)    live                   <= staged;
      end
   end

   always_comb begin
      rd_low             = '0;
      rd_low[7 -: LOW_W] = live[LOW_W-1:0];
      rd_high            = '0;
      rd_high[HIGH_W-1:0] = live[CODE_W-1:LOW_W];
   end

   assign code = live;

   // R2
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(live) |-> $past(load));

endmodule

// File: rtl/qdb_regif.sv
module qdb_regif #(
   parameter int         NCH       = 4,
   parameter logic [7:0] BASE_ADDR = 8'h10,
   parameter logic [7:0] CTRL_ADDR = 8'h1A,
   parameter logic [7:0] LOAD_ADDR = 8'h1C,
   parameter int         MODE_BIT  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [7:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic [NCH*8-1:0] rd_low_all,
   input  logic [NCH*8-1:0] rd_high_all,
   output logic [NCH-1:0]   low_we,
   output logic [NCH-1:0]   high_we,
   output logic             sw_mode,
   output logic [NCH-1:0]   sw_ld
);
   import qdb_pkg::*;

   logic   ctrl_wr;
   logic   load_wr;
   ld_src_e src_q;

   assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
   assign load_wr = bus_wr && (bus_addr == LOAD_ADDR);

   for (genvar i = 0; i < NCH; i++) begin : g_dec
      localparam logic [7:0] A_LOW  = 8'(BASE_ADDR + 2*i);
      localparam logic [7:0] A_HIGH = 8'(BASE_ADDR + 2*i + 1);
      assign low_we[i]  = bus_wr && (bus_addr == A_LOW);
      assign high_we[i] = bus_wr && (bus_addr == A_HIGH);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= LDSRC_PIN;
         sw_ld <= '0;
      end else begin
         if (ctrl_wr) src_q <= ld_src_e'(bus_wdata[MODE_BIT]);
         sw_ld <= (load_wr && src_q == LDSRC_SW) ? bus_wdata[NCH-1:0] : '0;
      end
   end

   assign sw_mode = (src_q == LDSRC_SW);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == CTRL_ADDR) bus_rdata[MODE_BIT] = sw_mode;
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == 8'(BASE_ADDR + 2*i))     bus_rdata = rd_low_all[i*8 +: 8];
         if (bus_addr == 8'(BASE_ADDR + 2*i + 1)) bus_rdata = rd_high_all[i*8 +: 8];
      end
   end

   // R7
   strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|sw_ld && !load_wr) |=> sw_ld == '0);

   // R8
   pin_mode_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_wr && !sw_mode) |=> sw_ld == '0);

endmodule

// File: rtl/quad_dac_bank.sv
module quad_dac_bank #(
   parameter int         NCH         = 4,
   parameter int         CODE_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] BASE_ADDR   = 8'h10,
   parameter logic [7:0] CTRL_ADDR   = 8'h1A,
   parameter logic [7:0] LOAD_ADDR   = 8'h1C,
   parameter int         MODE_BIT    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [7:0]            bus_addr,
   input  logic [7:0]            bus_wdata,
   output logic [7:0]            bus_rdata,
   input  logic                  load_n,
   output logic [NCH*CODE_W-1:0] dac_code
);
   import qdb_pkg::*;

   localparam int LOW_W  = low_field_w(CODE_W);
   localparam int HIGH_W = CODE_W - LOW_W;

   if (!code_w_ok(CODE_W)) begin : g_bad_w
      $error("quad_dac_bank: CODE_W must be 8, 10 or 12");
   end
   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("quad_dac_bank: NCH must be 1..8");
   end
   if (int'(BASE_ADDR) + 2*NCH > int'(CTRL_ADDR) || CTRL_ADDR == LOAD_ADDR) begin : g_bad_map
      $error("quad_dac_bank: channel addresses overlap control registers");
   end
   if (MODE_BIT < 0 || MODE_BIT > 7) begin : g_bad_bit
      $error("quad_dac_bank: MODE_BIT out of range");
   end

   logic             pin_fall;
   logic             sw_mode;
   logic [NCH-1:0]   sw_ld;
   logic [NCH-1:0]   low_we;
   logic [NCH-1:0]   high_we;
   logic [NCH-1:0]   ld_vec;
   logic [NCH*8-1:0] rd_low_all;
   logic [NCH*8-1:0] rd_high_all;

   qdb_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (load_n),
      .fall  (pin_fall)
   );

   qdb_regif #(
      .NCH       (NCH),
      .BASE_ADDR (BASE_ADDR),
      .CTRL_ADDR (CTRL_ADDR),
      .LOAD_ADDR (LOAD_ADDR),
      .MODE_BIT  (MODE_BIT)
   ) u_regif (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .rd_low_all  (rd_low_all),
      .rd_high_all (rd_high_all),
      .low_we      (low_we),
      .high_we     (high_we),
      .sw_mode     (sw_mode),
      .sw_ld       (sw_ld)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign ld_vec[i] = sw_mode ? sw_ld[i] : pin_fall;

      qdb_channel #(.CODE_W(CODE_W), .LOW_W(LOW_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .low_we  (low_we[i]),
         .high_we (high_we[i]),
         .wdata   (bus_wdata),
         .load    (ld_vec[i]),
         .code    (dac_code[i*CODE_W +: CODE_W]),
         .rd_low  (rd_low_all[i*8 +: 8]),
         .rd_high (rd_high_all[i*8 +: 8])
      );

      // R3
      readback_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == 8'(BASE_ADDR + 2*i + 1)) |->
            bus_rdata[HIGH_W-1:0] == dac_code[i*CODE_W + LOW_W +: HIGH_W]);

      // R3
      readback_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == 8'(BASE_ADDR + 2*i)) |->
            bus_rdata[7 -: LOW_W] == dac_code[i*CODE_W +: LOW_W]);
   end

   // R6
   sw_mode_pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode && !(|sw_ld)) |=> $stable(dac_code));

endmodule

// File: tb/quad_dac_bank_test.sv
module quad_dac_bank_test;
   localparam logic [7:0] CTRL = 8'h1A;
   localparam logic [7:0] LOADR = 8'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        load_n = 1'b1;
   logic [31:0] dac_code;

   int vectors = 0;
   int misses  = 0;

   logic [7:0] m_stage [4];
   logic [7:0] m_live  [4];
   logic       m_sw;

   always #2 clk = ~clk;

   quad_dac_bank uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .load_n    (load_n),
      .dac_code  (dac_code)
   );

   function automatic logic [7:0] exp_read(input logic [7:0] a);
      if (a >= 8'h10 && a <= 8'h17) begin
         if (a[0]) return {2'b00, m_live[(a - 8'h10) >> 1][7:2]};
         else      return {m_live[(a - 8'h10) >> 1][1:0], 6'b0};
      end
      if (a == CTRL) return {4'b0, m_sw, 3'b0};
      return 8'h00;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_codes(input string req);
      for (int i = 0; i < 4; i++) chk(req, dac_code[i*8 +: 8], m_live[i]);
   endtask

   task automatic chk_read(input string req, input logic [7:0] a);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp_read(a));
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a >= 8'h10 && a <= 8'h17) begin
         if (a[0]) m_stage[(a - 8'h10) >> 1][7:2] = d[5:0];
         else      m_stage[(a - 8'h10) >> 1][1:0] = d[7:6];
      end
      if (a == CTRL) m_sw = d[3];
   endtask

   // Pin pulse: low for 5 cycles, then high for 4 cycles.
   task automatic pin_pulse(input string req);
      load_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk_codes(req);
      @(negedge clk);
      if (!m_sw) for (int i = 0; i < 4; i++) m_live[i] = m_stage[i];
      chk_codes(req);
      @(negedge clk); @(negedge clk);
      load_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic sw_load(input string req, input logic [3:0] m);
      wr(LOADR, {4'b0, m});
      chk_codes(req);
      @(negedge clk);
      if (m_sw) for (int i = 0; i < 4; i++) if (m[i]) m_live[i] = m_stage[i];
      chk_codes(req);
      chk_read(req, LOADR);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      misses++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED));
      for (int i = 0; i < 4; i++) begin m_stage[i] = 8'h00; m_live[i] = 8'h00; end
      m_sw = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk_codes("R1");
      for (int a = 8'h10; a <= 8'h1C; a++) chk_read("R1", 8'(a));

      // R2 / R3: staged writes do not reach output or readback
      wr(8'h10, 8'hC0); wr(8'h11, 8'h2A); wr(8'h13, 8'h15); wr(8'h16, 8'h40);
      chk_codes("R2");
      chk_read("R3", 8'h11);
      chk_read("R3", 8'h10);

      // R4: pin load timing
      pin_pulse("R4");
      chk_read("R3", 8'h11);
      chk_read("R3", 8'h10);

      // R5: pin held low loads once
      load_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 4; i++) m_live[i] = m_stage[i];
      chk_codes("R5");
      wr(8'h15, 8'h3F);
      repeat (5) @(negedge clk);
      chk_codes("R5");
      load_n = 1'b1;
      repeat (4) @(negedge clk);
      chk_codes("R5");
      pin_pulse("R5");
      chk(  "R5", dac_code[23:16], 8'hFC);

      // R8: software load ignored in pin mode
      wr(8'h17, 8'h01);
      sw_load("R8", 4'hF);

      // R6: switch to software mode; pin ignored
      wr(CTRL, 8'h08);
      chk_read("R6", CTRL);
      pin_pulse("R6");

      // R7: partial mask
      sw_load("R7", 4'b1000);
      wr(8'h10, 8'h40); wr(8'h12, 8'h80);
      sw_load("R7", 4'b0010);
      @(negedge clk);
      chk_codes("R7");

      // R9: bits outside fields ignored
      wr(8'h10, 8'h3F); wr(8'h11, 8'hFF);
      sw_load("R9", 4'b0001);
      chk("R9", dac_code[7:0], 8'hFC);
      wr(8'h10, 8'hFF); wr(8'h11, 8'hC0);
      sw_load("R9", 4'b0001);
      chk("R9", dac_code[7:0], 8'h03);

      // Constrained random mix
      for (int n = 0; n < 400; n++) begin
         int unsigned op;
         op = $urandom_range(0, 9);
         if (op <= 4) begin
            wr(8'(8'h10 + $urandom_range(0, 7)), 8'($urandom()));
            chk_codes("R2");
         end else if (op == 5) begin
            pin_pulse(m_sw ? "R6" : "R4");
         end else if (op <= 7) begin
            sw_load(m_sw ? "R7" : "R8", 4'($urandom()));
         end else if (op == 8) begin
            wr(CTRL, 8'($urandom()));
            chk_read("R6", CTRL);
         end else begin
            chk_read("R3", 8'(8'h10 + $urandom_range(0, 7)));
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule